// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Framing-Error Flag

This block is the receive half of a classic microcontroller serial port. It covers the three asynchronous modes: one with 8 data bits, and two with 9 data bits. An external baud generator supplies a tick at sixteen times the bit rate. The receiver uses that tick to find each start bit and to take a majority vote near the middle of every bit. Data bits arrive least significant bit first. In the 9-bit modes the ninth bit goes into a dedicated status bit. The receiver depends on nothing outside itself, so a transmitter running at a different rate can sit beside it.

Software controls and observes the receiver through two 8-bit registers on a small write/read port: a serial control register and a power-control register. A bit in the power-control register turns on stop-bit checking. While checking is on, bit 7 of the serial control register reads and writes a sticky framing-error flag. While checking is off, the same bit position reaches the most significant mode bit. Turning the check on also moves the receive-complete flag from the end of the last data bit to the middle of the stop bit.

The receive-complete flag is the block's only flow control. A frame is delivered only while the flag is clear, and software clears it by writing the control register. A frame that completes while the flag is still set is dropped, and the previous byte stays in place.

Top module: `uart_rx_fe`

## Requirements
- R1: The mode is taken from control bits 7 and 6 (SM0, SM1). 01 selects 8 data bits. 10 and 11 select 9 data bits. 00 means the receiver stays idle. Data arrives LSB first, and bits 7:0 appear on `rx_byte` once a frame is accepted.
- R2: Each bit lasts 16 baud ticks. A start is recognised on a 1-to-0 change of `rxd` seen at a tick. The bit value is the majority of samples 7, 8 and 9, counted from the first low tick as sample 1. A start bit whose majority is 1 is dropped as a glitch.
- R3: On acceptance, RB8 (control bit 2) takes the ninth data bit in the 9-bit modes and the stop-bit value in the 8-bit mode.
- R4: With checking off, RI (control bit 0) rises on the 16th tick of the last data bit of an accepted frame.
- R5: With checking on, RI rises on the 9th tick of the stop bit of an accepted frame.
- R6: A frame is accepted only if RI is clear and REN (control bit 4) is set at the decision point. When a frame is refused, `rx_byte`, RB8 and RI stay unchanged.
- R7: When SM2 (control bit 5) is 1, the 9-bit modes accept only a frame whose ninth bit is 1. With checking on, the 8-bit mode accepts only a frame whose stop bit is 1. With checking off, SM2 does not affect the 8-bit mode.
- R8: With checking on and the receiver running, a stop bit sampled as 0 sets FE. FE is set even when the frame is refused. With checking off, FE is never set.
- R9: Once set, FE stays set through later frames with good stop bits. Only reset, or a write of 0 to control bit 7 while checking is on, clears it.
- R10: Control bit 7 reads and writes FE when SMOD0 is 1 and SM0 when SMOD0 is 0. The two bits have separate storage, so changing SMOD0 alters neither of them.
- R11: Address 0 is the control register: bit 6 SM1, bit 5 SM2, bit 4 REN, bit 2 RB8, bit 0 RI, with bits 3 and 1 reading 0. Address 1 holds SMOD0 at bit 6, and its other bits read 0. A write takes effect on the next clock. A hardware update in the same cycle wins over the write.
- R12: After reset every register bit, `rx_byte`, `rx_ri`, `rx_rb8` and `rx_fe` read 0.
- R13: With REN clear or mode 00, incoming frames change none of the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0: control register, 1: power-control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| rx_byte | output | 8 | Last accepted data byte |
| rx_ri | output | 1 | Receive-complete flag |
| rx_rb8 | output | 1 | Ninth bit, or stop bit in 8-bit mode |
| rx_fe | output | 1 | Sticky framing-error flag |

## Verification
A wrong bit counter or sample phase shows up as a corrupted `rx_byte` or RB8 at the end of the same frame. A misplaced decision point moves the rise of RI by whole bits or by half a bit, and the bench sees this on the very tick where the rise is due. A wrong acceptance, SM2 or FE state becomes visible only once a frame finishes: a flag fails to rise, or a held byte changes. A mix-up in the shared bit 7 storage appears on the next register read after SMOD0 is toggled.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_PWR  = 1'b1;

  // control-register bit positions
  localparam int B_MODE_HI = 7;
  localparam int B_MODE_LO = 6;
  localparam int B_MULTI   = 5;
  localparam int B_EN      = 4;
  localparam int B_NINTH   = 2;
  localparam int B_DONE    = 0;
  // power-control bit position
  localparam int B_CHECK   = 6;

  function automatic logic mode_nine(input logic m_hi);
    return m_hi;
  endfunction

  function automatic logic mode_active(input logic m_hi, input logic m_lo);
    return m_hi | m_lo;
  endfunction
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic active,
  input  logic rxd,
  output logic mid,
  output logic bit_end,
  output logic maj
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID_C  = CW'(OVS / 2);
  localparam logic [CW-1:0] PRE2_C = CW'(OVS / 2 - 2);
  localparam logic [CW-1:0] PRE1_C = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST_C = CW'(OVS - 1);

  logic [CW-1:0] cnt;
  logic          s_a, s_b;

  // while idle the counter parks at 1 so the start-detection tick counts as 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      s_a <= 1'b1;
      s_b <= 1'b1;
    end else if (tick) begin
      if (!active) cnt <= CW'(1);
      else if (cnt == LAST_C) cnt <= '0;
      else cnt <= cnt + CW'(1);
      if (active && cnt == PRE2_C) s_a <= rxd;
      if (active && cnt == PRE1_C) s_b <= rxd;
    end
  end

  assign mid     = tick && active && (cnt == MID_C);
  assign bit_end = tick && active && (cnt == LAST_C);
  assign maj     = (s_a & s_b) | (s_a & rxd) | (s_b & rxd);
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              run,
  input  logic              nine,
  output logic [DATA_W:0]   data,
  output logic              last_end,
  output logic              stop_smp,
  output logic              stop_bit
);
  localparam int IW = $clog2(DATA_W + 1);

  rx_state_e       state;
  logic            prev;
  logic [IW-1:0]   idx;
  logic [IW-1:0]   last_idx;
  logic            mid, bit_end, maj;

  assign last_idx = nine ? IW'(DATA_W) : IW'(DATA_W - 1);

  uart_rx_sampler #(.OVS(OVS)) u_smp (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .active  (state != RX_IDLE),
    .rxd     (rxd),
    .mid     (mid),
    .bit_end (bit_end),
    .maj     (maj)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      prev  <= 1'b1;
      idx   <= '0;
      data  <= '0;
    end else begin
      if (tick) prev <= rxd;
      if (!run) begin
        state <= RX_IDLE;
      end else begin
        unique case (state)
          RX_IDLE:  if (tick && prev && !rxd) state <= RX_START;
          RX_START: begin
            if (mid && maj) state <= RX_IDLE;
            else if (bit_end) begin
              state <= RX_DATA;
              idx   <= '0;
            end
          end
          RX_DATA: begin
            if (mid) data[idx] <= maj;
            if (bit_end) begin
              if (idx == last_idx) state <= RX_STOP;
              else idx <= idx + IW'(1);
            end
          end
          RX_STOP:  if (mid) state <= RX_IDLE;
          default:  state <= RX_IDLE;
        endcase
      end
    end
  end

  assign last_end = run && (state == RX_DATA) && bit_end && (idx == last_idx);
  assign stop_smp = run && (state == RX_STOP) && mid;
  assign stop_bit = maj;
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [DATA_W:0]   data,
  input  logic              last_end,
  input  logic              stop_smp,
  input  logic              stop_bit,
  output logic              sm0,
  output logic              sm1,
  output logic              ren,
  output logic              smod0,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_ri,
  output logic              rx_rb8,
  output logic              rx_fe
);
  logic sm2, pend_rb8, nine, running, acc_off, acc_on, wr_ctrl, wr_pwr;

  assign nine    = mode_nine(sm0);
  assign running = ren && mode_active(sm0, sm1);
  assign wr_ctrl = reg_we && (reg_addr == ADDR_CTRL);
  assign wr_pwr  = reg_we && (reg_addr == ADDR_PWR);
  assign acc_off = !rx_ri && running && (!sm2 || !nine || data[DATA_W]);
  assign acc_on  = !rx_ri && running && (!sm2 || (nine ? data[DATA_W] : stop_bit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sm0 <= 1'b0; sm1 <= 1'b0; sm2 <= 1'b0; ren <= 1'b0;
      smod0 <= 1'b0; rx_fe <= 1'b0; rx_ri <= 1'b0; rx_rb8 <= 1'b0;
      rx_byte <= '0; pend_rb8 <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        sm1    <= reg_wdata[B_MODE_LO];
        sm2    <= reg_wdata[B_MULTI];
        ren    <= reg_wdata[B_EN];
        rx_rb8 <= reg_wdata[B_NINTH];
        rx_ri  <= reg_wdata[B_DONE];
        if (smod0) rx_fe <= reg_wdata[B_MODE_HI];
        else       sm0   <= reg_wdata[B_MODE_HI];
      end
      if (wr_pwr) smod0 <= reg_wdata[B_CHECK];
      // hardware updates follow the software write, so they take priority
      if (last_end && !smod0) begin
        if (acc_off) begin
          rx_byte <= data[DATA_W-1:0];
          rx_ri   <= 1'b1;
          if (nine) rx_rb8 <= data[DATA_W];
        end
        pend_rb8 <= acc_off && !nine;
      end
      if (stop_smp) begin
        if (smod0) begin
          if (!stop_bit) rx_fe <= 1'b1;
          if (acc_on) begin
            rx_byte <= data[DATA_W-1:0];
            rx_ri   <= 1'b1;
            rx_rb8  <= nine ? data[DATA_W] : stop_bit;
          end
        end else if (pend_rb8) begin
          rx_rb8 <= stop_bit;
        end
        pend_rb8 <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_CTRL) begin
      reg_rdata[B_MODE_HI] = smod0 ? rx_fe : sm0;
      reg_rdata[B_MODE_LO] = sm1;
      reg_rdata[B_MULTI]   = sm2;
      reg_rdata[B_EN]      = ren;
      reg_rdata[B_NINTH]   = rx_rb8;
      reg_rdata[B_DONE]    = rx_ri;
    end else begin
      reg_rdata[B_CHECK]   = smod0;
    end
  end
endmodule

// File: rtl/uart_rx_fe.sv
module uart_rx_fe
  import uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rxd,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_ri,
  output logic              rx_rb8,
  output logic              rx_fe
);
  logic [DATA_W:0] data;
  logic last_end, stop_smp, stop_bit;
  logic sm0, sm1, ren, smod0;

  uart_rx_framer #(.OVS(OVS), .DATA_W(DATA_W)) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (baud_tick),
    .rxd      (rxd),
    .run      (ren && mode_active(sm0, sm1)),
    .nine     (mode_nine(sm0)),
    .data     (data),
    .last_end (last_end),
    .stop_smp (stop_smp),
    .stop_bit (stop_bit)
  );

  uart_rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .data      (data),
    .last_end  (last_end),
    .stop_smp  (stop_smp),
    .stop_bit  (stop_bit),
    .sm0       (sm0),
    .sm1       (sm1),
    .ren       (ren),
    .smod0     (smod0),
    .rx_byte   (rx_byte),
    .rx_ri     (rx_ri),
    .rx_rb8    (rx_rb8),
    .rx_fe     (rx_fe)
  );
endmodule

// File: rtl/uart_rx_fe_chk.sv
module uart_rx_fe_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              reg_addr,
  input logic [DATA_W-1:0] rx_byte,
  input logic              rx_ri,
  input logic              rx_fe,
  input logic              smod0,
  input logic              sm0,
  input logic              sm1
);
  logic ctrl_wr;
  assign ctrl_wr = reg_we && (reg_addr == 1'b0);

  assert_ri_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ri && !ctrl_wr) |=> rx_ri);

  assert_byte_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ri && !ctrl_wr) |=> $stable(rx_byte));

  assert_fe_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fe && !(ctrl_wr && smod0)) |=> rx_fe);

  assert_fe_needs_check_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_fe && !smod0) |=> !rx_fe);

  assert_mode_bit_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ctrl_wr && !smod0)) |=> $stable(sm0));

  assert_mode0_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!sm0 && !sm1 && !rx_ri && !ctrl_wr) |=> !rx_ri);
endmodule

bind uart_rx_fe uart_rx_fe_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .rx_byte  (rx_byte),
  .rx_ri    (rx_ri),
  .rx_fe    (rx_fe),
  .smod0    (smod0),
  .sm0      (sm0),
  .sm1      (sm1)
);

// File: tb/test_uart_rx_fe.sv
module test_uart_rx_fe;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, baud_tick = 1'b0, rxd = 1'b1;
  logic       reg_we = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata, rx_byte;
  logic       rx_ri, rx_rb8, rx_fe;

  uart_rx_fe i_uart_rx_fe (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_byte(rx_byte), .rx_ri(rx_ri),
    .rx_rb8(rx_rb8), .rx_fe(rx_fe)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  logic m_ri = 0, m_fe = 0, m_rb8 = 0;
  logic [7:0] m_byte = 0;
  logic c_sm0 = 0, c_sm1 = 0, c_sm2 = 0, c_ren = 0, c_chk = 0;

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick_n(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) baud_tick = 1'b1;
      @(negedge clk) baud_tick = 1'b0;
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk) begin reg_addr = a; reg_we = 1'b1; reg_wdata = d; end
    @(negedge clk) reg_we = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk) reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic configure(logic sm0, logic sm1, logic sm2, logic ren,
                           logic chk_on, logic ri0, logic fe0);
    wr(1'b1, 8'h00);
    wr(1'b0, {sm0, sm1, sm2, ren, 1'b0, m_rb8, 1'b0, ri0});
    wr(1'b1, {1'b0, chk_on, 6'b0});
    if (chk_on) begin
      wr(1'b0, {fe0, sm1, sm2, ren, 1'b0, m_rb8, 1'b0, ri0});
      m_fe = fe0;
    end
    m_ri = ri0;
    c_sm0 = sm0; c_sm1 = sm1; c_sm2 = sm2; c_ren = ren; c_chk = chk_on;
  endtask

  function automatic logic accepts(logic [8:0] d, logic stop);
    logic nine = c_sm0;
    logic run = c_ren && (c_sm0 || c_sm1);
    return run && !m_ri && (!c_sm2 || (nine ? d[8] : (c_chk ? stop : 1'b1)));
  endfunction

  task automatic send_frame(logic [8:0] d, logic stop, bit timing);
    logic nine = c_sm0;
    int nd = nine ? 9 : 8;
    logic run = c_ren && (c_sm0 || c_sm1);
    logic acc = accepts(d, stop);
    @(negedge clk) rxd = 1'b0;
    tick_n(16);
    for (int i = 0; i < nd; i++) begin
      rxd = d[i];
      if (timing && !c_chk && i == nd - 1) begin
        tick_n(15);
        chk("R4", "ri one tick early", {7'b0, rx_ri}, 8'h00);
        tick_n(1);
        chk("R4", "ri at last data end", {7'b0, rx_ri}, {7'b0, acc});
      end else tick_n(16);
    end
    rxd = stop;
    if (timing && c_chk) begin
      tick_n(8);
      chk("R5", "ri one tick early", {7'b0, rx_ri}, 8'h00);
      tick_n(1);
      chk("R5", "ri at stop sample", {7'b0, rx_ri}, {7'b0, acc});
      tick_n(7);
    end else tick_n(16);
    rxd = 1'b1;
    tick_n(3);
    if (acc) begin
      m_byte = d[7:0]; m_ri = 1'b1; m_rb8 = nine ? d[8] : stop;
    end
    if (run && c_chk && !stop) m_fe = 1'b1;
  endtask

  task automatic check_outs(string tag);
    chk("R1", {tag, " byte"}, rx_byte, m_byte);
    chk("R3", {tag, " rb8"}, {7'b0, rx_rb8}, {7'b0, m_rb8});
    chk("R6", {tag, " ri"}, {7'b0, rx_ri}, {7'b0, m_ri});
    chk("R8", {tag, " fe"}, {7'b0, rx_fe}, {7'b0, m_fe});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "ri", {7'b0, rx_ri}, 8'h00);
    chk("R12", "fe", {7'b0, rx_fe}, 8'h00);
    chk("R12", "rb8/byte", {rx_rb8, rx_byte[6:0]}, 8'h00);
    rd(1'b0, v); chk("R12", "ctrl read", v, 8'h00);
    rd(1'b1, v); chk("R12", "pwr read", v, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    tick_n(4);

    // R11 register map
    wr(1'b0, 8'hFF); rd(1'b0, v); chk("R11", "ctrl all ones", v, 8'hF5);
    wr(1'b1, 8'hFF); rd(1'b1, v); chk("R11", "pwr all ones", v, 8'h40);
    rd(1'b0, v); chk("R10", "bit7 shows fe", v, 8'h75);
    wr(1'b1, 8'h00); wr(1'b0, 8'h00);
    m_ri = 0; m_rb8 = 0;

    // R1/R3/R4 mode 1, check off
    configure(0, 1, 0, 1, 0, 0, 0);
    send_frame(9'h0A5, 1'b1, 1'b1); check_outs("mode1 off");
    // R5 mode 3, check on, ninth bit 0
    configure(1, 1, 0, 1, 1, 0, 0);
    send_frame(9'h03C, 1'b1, 1'b1); check_outs("mode3 on");
    // R8 bad stop sets FE
    configure(0, 1, 0, 1, 1, 0, 0);
    send_frame(9'h05A, 1'b0, 1'b1); check_outs("bad stop");
    // R9 later good frame keeps FE
    configure(0, 1, 0, 1, 1, 0, m_fe);
    send_frame(9'h0C3, 1'b1, 1'b1);
    chk("R9", "fe after good frame", {7'b0, rx_fe}, 8'h01);
    // R10 shared bit 7, separate storage
    wr(1'b1, 8'h00); rd(1'b0, v); chk("R10", "bit7 = sm0", {7'b0, v[7]}, 8'h00);
    wr(1'b1, 8'h40); rd(1'b0, v); chk("R10", "bit7 = fe", {7'b0, v[7]}, 8'h01);
    wr(1'b0, 8'h50); m_ri = 0;
    chk("R9", "fe cleared by write", {7'b0, rx_fe}, 8'h00);
    wr(1'b1, 8'h00); wr(1'b0, 8'hD0); wr(1'b1, 8'h40);
    rd(1'b0, v); chk("R10", "fe kept after sm0 write", {7'b0, v[7]}, 8'h00);
    m_fe = 0;

    // R2 glitch rejection, then a clean frame
    configure(0, 1, 0, 1, 0, 0, 0);
    @(negedge clk) rxd = 1'b0; tick_n(5); rxd = 1'b1; tick_n(20);
    chk("R2", "glitch gives no ri", {7'b0, rx_ri}, 8'h00);
    send_frame(9'h181, 1'b1, 1'b0); check_outs("R2 after glitch");

    // R6 frame dropped while RI is set
    send_frame(9'h077, 1'b1, 1'b0);
    chk("R6", "held byte", rx_byte, 8'h81);

    // R7 multiprocessor filtering
    configure(1, 0, 1, 1, 0, 0, 0);
    send_frame(9'h033, 1'b1, 1'b0);
    chk("R7", "ninth 0 refused", {7'b0, rx_ri}, 8'h00);
    send_frame(9'h133, 1'b1, 1'b0);
    chk("R7", "ninth 1 accepted", rx_byte, 8'h33);
    configure(0, 1, 1, 1, 1, 0, 0);
    send_frame(9'h044, 1'b0, 1'b0);
    chk("R7", "mode1 bad stop refused", {7'b0, rx_ri}, 8'h00);
    check_outs("R7 mode1");

    // R13 idle in mode 0 and with REN clear
    configure(0, 0, 0, 1, 0, 0, 0);
    send_frame(9'h0EE, 1'b1, 1'b0); check_outs("R13 mode0");
    configure(1, 1, 0, 0, 1, 0, 0);
    send_frame(9'h0DD, 1'b0, 1'b0); check_outs("R13 ren off");

    // constrained random frames
    for (int n = 0; n < 40; n++) begin
      logic [1:0] md = 2'($urandom_range(1, 3));
      logic ck = 1'($urandom);
      logic s2 = ($urandom_range(0, 3) == 0);
      logic en = ($urandom_range(0, 7) != 0);
      logic r0 = ($urandom_range(0, 5) == 0);
      logic f0 = ($urandom_range(0, 3) == 0);
      logic st = ($urandom_range(0, 6) != 0);
      logic [8:0] d = 9'($urandom);
      configure(md[1], md[0], s2, en, ck, r0, ck ? f0 : m_fe);
      rd(1'b0, v);
      chk("R10", "bit7 view", {7'b0, v[7]}, {7'b0, ck ? m_fe : md[1]});
      send_frame(d, st, !r0);
      check_outs("random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule